// File: doc/BRIEF.md
# Shared Timebase Counter with Per-Core Compare Interrupts

This block holds one free-running counter that every core in a cluster shares. Each core has a private 64-bit compare register. A core's timer interrupt rises once the counter has reached its compare value. The counter width is a build parameter between 32 and 64 bits, in steps of 4. Software reads the width from a field in the configuration word and can freeze the count with a halt bit in the same word.

All access goes through one 32-bit register bus. Each bus access carries the index of the core that issues it. The counter is read as two 32-bit words with no atomic snapshot, so software must reread the upper word to detect a carry between the two reads. A compare value is written upper word first. The upper word is held aside, and the full 64-bit value takes effect only when the lower word is written. Each core also owns a peer-select register. Through a separate pair of window addresses it can read or program the compare value of whichever core that register names.

Top module: `shared_timebase`

## Requirements
- R1: After reset the counter is zero and running, the halt bit is 0, every compare value reads all-ones, every peer-select register is 0 and every timer interrupt is low.
- R2: While not halted the counter advances by exactly one per clock and wraps to zero after 2^CNT_W - 1.
- R3: Word 0 (config) reads the width code (CNT_W-32)/4 in bits [3:0] and the halt bit in bit 16, with all other bits zero. Only bit 16 is writable; writes to the other bits have no effect.
- R4: Writing 1 to the halt bit freezes the counter from the next cycle. Writing 0 resumes counting from the held value.
- R5: Word 1 reads counter bits [31:0] and word 2 reads bits [63:32]. Counter bits at or above CNT_W read as zero.
- R6: A write to the upper compare word (word 4 local, word 7 peer) only stages the value. The active compare value and the interrupt are unchanged until the lower word is written.
- R7: A write to the lower compare word (word 3 local, word 6 peer) loads {staged upper, written lower} into the active compare value. Words 3/4 and 6/7 read back the active value's low and high halves.
- R8: A core's interrupt is registered. It goes high the cycle after counter >= compare is seen and stays high until a lower-word write to that core's compare. That write clears it for one cycle, after which the new value is evaluated.
- R9: Word 5 is the issuing core's peer-select register, holding a core index in its low bits. Words 6 and 7 access the compare registers of the selected core.
- R10: A compare write affects only the targeted core's compare value and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_core | input | IDX_W | Index of the core issuing the access |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| timer_irq | output | NUM_CORES | Per-core timer interrupt |

## Verification
On every cycle, the assertions check the increment and freeze of the counter, the rule that an upper-word write leaves the active compare value alone, and the set, hold and clear behaviour of each interrupt flag. They also check that at most one compare slot commits per cycle. The bench scenarios cover what spans whole register sequences: the exact reset values, readback of the width code and the masked config bits, and counter values observed several cycles apart. They also show interrupts that follow a staged-then-committed compare, peer-window redirection between cores, and zero upper bits on a 32-bit build. Wrap-around at 2^CNT_W is left to the assertion, since no bench run reaches it.

// File: rtl/shared_timebase_pkg.sv
package shared_timebase_pkg;
    // Word addresses of the register bus.
    typedef enum logic [2:0] {
        A_CFG     = 3'd0,
        A_CNT_LO  = 3'd1,
        A_CNT_HI  = 3'd2,
        A_CMP_LO  = 3'd3,
        A_CMP_HI  = 3'd4,
        A_PEERSEL = 3'd5,
        A_PCMP_LO = 3'd6,
        A_PCMP_HI = 3'd7
    } tb_addr_e;

    localparam int HALT_BIT = 16;
endpackage

// File: rtl/tb_counter.sv
// Shared timebase counter.
// Counts up by one per clock unless halted; wraps at 2^CNT_W.
// Assumes CNT_W lies in 32..64.
module tb_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_wr,
    input  logic             halt_val,
    output logic             halt_q,
    output logic [CNT_W-1:0] count_q
);
    // Halt control bit, written from the config word.
    always_ff @(posedge clk) begin
        if (!rst_n)       halt_q <= 1'b0;
        else if (halt_wr) halt_q <= halt_val;
    end

    // Counter advance; the natural width gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (!halt_q) count_q <= count_q + 1'b1;
    end

    a_r4_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> $stable(count_q));
    a_r2_run_step: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_q |=> count_q == CNT_W'($past(count_q) + 1'b1));
endmodule

// File: rtl/tb_cmp_slot.sv
// One core's compare register and its sticky timer interrupt.
// The upper word is staged; a lower-word write commits the full value.
// Assumes wr_hi and wr_lo are single-cycle strobes.
module tb_cmp_slot (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] count,
    input  logic        wr_hi,
    input  logic        wr_lo,
    input  logic [31:0] wdata,
    output logic [63:0] cmp_q,
    output logic        irq_q
);
    logic [31:0] hi_stage_q;

    // Upper-word staging register.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_stage_q <= '1;
        else if (wr_hi) hi_stage_q <= wdata;
    end

    // Active compare value, loaded only on a lower-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmp_q <= '1;
        else if (wr_lo) cmp_q <= {hi_stage_q, wdata};
    end

    // Sticky interrupt flag, cleared by a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_q <= 1'b0;
        else if (wr_lo) irq_q <= 1'b0;
        else            irq_q <= irq_q | (count >= cmp_q);
    end

    a_r6_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> $stable(cmp_q));
    a_r8_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && count >= cmp_q) |=> irq_q);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !wr_lo) |=> irq_q);
    a_r8_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !irq_q);
endmodule

// File: rtl/shared_timebase.sv
// Shared timebase with per-core compare interrupts and a peer window.
// Bus reads are combinational; writes take effect at the clock edge.
// Assumes NUM_CORES is a power of two, so every peer index is valid.
module shared_timebase
    import shared_timebase_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 64,
    parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     bus_core,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] timer_irq
);
    localparam logic [3:0] WCODE = 4'((CNT_W - 32) / 4);

    logic             halt_q;
    logic [CNT_W-1:0] count_q;
    logic [63:0]      count64;
    logic [IDX_W-1:0] peer_q [NUM_CORES];
    logic [63:0]      cmp    [NUM_CORES];
    logic [NUM_CORES-1:0] wr_hi, wr_lo;
    logic [IDX_W-1:0] peer_cur;
    tb_addr_e         addr;

    assign addr     = tb_addr_e'(bus_addr);
    assign count64  = 64'(count_q);
    assign peer_cur = peer_q[bus_core];

    tb_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_wr  (bus_we && addr == A_CFG),
        .halt_val (bus_wdata[HALT_BIT]),
        .halt_q   (halt_q),
        .count_q  (count_q)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic is_local, is_peer;
        assign is_local = (bus_core == IDX_W'(c));
        assign is_peer  = (peer_cur == IDX_W'(c));
        assign wr_hi[c] = bus_we && ((is_local && addr == A_CMP_HI) ||
                                     (is_peer  && addr == A_PCMP_HI));
        assign wr_lo[c] = bus_we && ((is_local && addr == A_CMP_LO) ||
                                     (is_peer  && addr == A_PCMP_LO));

        // Peer-select register owned by this core.
        always_ff @(posedge clk) begin
            if (!rst_n)
                peer_q[c] <= '0;
            else if (bus_we && is_local && addr == A_PEERSEL)
                peer_q[c] <= bus_wdata[IDX_W-1:0];
        end

        tb_cmp_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .count (count64),
            .wr_hi (wr_hi[c]),
            .wr_lo (wr_lo[c]),
            .wdata (bus_wdata),
            .cmp_q (cmp[c]),
            .irq_q (timer_irq[c])
        );
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_CFG: begin
                bus_rdata[3:0]      = WCODE;
                bus_rdata[HALT_BIT] = halt_q;
            end
            A_CNT_LO:  bus_rdata = count64[31:0];
            A_CNT_HI:  bus_rdata = count64[63:32];
            A_CMP_LO:  bus_rdata = cmp[bus_core][31:0];
            A_CMP_HI:  bus_rdata = cmp[bus_core][63:32];
            A_PEERSEL: bus_rdata = 32'(peer_cur);
            A_PCMP_LO: bus_rdata = cmp[peer_cur][31:0];
            A_PCMP_HI: bus_rdata = cmp[peer_cur][63:32];
            default:   bus_rdata = '0;
        endcase
    end

    a_r10_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_lo));
endmodule

// File: tb/shared_timebase_tb.sv
module shared_timebase_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_core = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] timer_irq;
    logic [31:0] n_rdata;
    logic [1:0]  n_irq;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_timebase #(.NUM_CORES(NC), .CNT_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_core(bus_core), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timer_irq(timer_irq));

    shared_timebase #(.NUM_CORES(2), .CNT_W(32)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .bus_core(1'b0), .bus_addr(bus_addr),
        .bus_we(1'b0), .bus_wdata(32'h0), .bus_rdata(n_rdata),
        .timer_irq(n_irq));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int core, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_core = 2'(core); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int core, input logic [2:0] a, output logic [31:0] d);
        bus_core = 2'(core); bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, 3'd0, d); check("R1/R3 cfg", d, 32'h8);
        rd(2, 3'd3, d); check("R1 cmp lo", d, 32'hFFFF_FFFF);
        rd(3, 3'd4, d); check("R1 cmp hi", d, 32'hFFFF_FFFF);
        rd(1, 3'd5, d); check("R1 peer sel", d, 0);
        check("R1 irq", timer_irq, 0);
        rd(0, 3'd2, d); check("R1 cnt hi", d, 0);
    endtask

    task automatic t_run();
        logic [31:0] a, b;
        rd(0, 3'd1, a); cycles(4); rd(0, 3'd1, b);
        check("R2 step", b, a + 4);
    endtask

    task automatic t_cfg_halt();
        logic [31:0] a, b;
        wr(0, 3'd0, 32'hFFFF_FFFF);
        rd(0, 3'd0, a); check("R3 cfg mask", a, 32'h0001_0008);
        rd(0, 3'd1, a); cycles(5); rd(0, 3'd1, b);
        check("R4 frozen", b, a);
        wr(0, 3'd0, 32'h0);
        rd(0, 3'd1, b); check("R4 resume held", b, a);
        cycles(3); rd(0, 3'd1, b); check("R4 resume step", b, a + 3);
        wr(0, 3'd0, 32'h0001_0000);
    endtask

    task automatic t_compare(output logic [31:0] c);
        logic [31:0] d;
        rd(0, 3'd1, c);
        wr(1, 3'd4, 32'h0);
        cycles(1);
        rd(1, 3'd4, d); check("R6 staged hi not active", d, 32'hFFFF_FFFF);
        check("R6 irq unchanged", timer_irq[1], 1'b0);
        wr(1, 3'd3, c + 5);
        cycles(1);
        rd(1, 3'd4, d); check("R7 commit hi", d, 0);
        rd(1, 3'd3, d); check("R7 commit lo", d, c + 5);
        check("R8 no hit above count", timer_irq[1], 1'b0);
        wr(1, 3'd3, c);
        check("R8 commit cycle low", timer_irq[1], 1'b0);
        cycles(1);
        check("R8 hit", timer_irq[1], 1'b1);
        cycles(4);
        check("R8 sticky", timer_irq[1], 1'b1);
        check("R10 others idle", {timer_irq[3:2], timer_irq[0]}, 3'b000);
        wr(1, 3'd3, c + 100);
        cycles(1);
        check("R8 cleared by larger", timer_irq[1], 1'b0);
    endtask

    task automatic t_peer(input logic [31:0] c);
        logic [31:0] d;
        wr(0, 3'd5, 32'd2);
        rd(0, 3'd5, d); check("R9 peer sel readback", d, 2);
        wr(0, 3'd7, 32'h0);
        wr(0, 3'd6, c);
        cycles(1);
        check("R9 peer irq", timer_irq[2], 1'b1);
        check("R10 issuer irq", timer_irq[0], 1'b0);
        rd(2, 3'd3, d); check("R9 target local lo", d, c);
        rd(0, 3'd6, d); check("R9 window lo", d, c);
        rd(0, 3'd3, d); check("R10 issuer cmp", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_narrow();
        logic [31:0] d;
        bus_addr = 3'd2; #1 d = n_rdata; check("R5 upper zero", d, 0);
        bus_addr = 3'd0; #1 d = n_rdata; check("R3 narrow code", d, 0);
    endtask

    initial begin
        logic [31:0] c;
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run();
        t_cfg_halt();
        t_compare(c);
        t_peer(c);
        t_narrow();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule